// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is a single compare channel that sits next to a free-running time-base counter. Each cycle it compares the counter value with an active compare register. It builds an active-high reference waveform from that comparison according to a 3-bit mode. Polarity and an enable are then applied to form the channel pin. It raises a compare flag and an interrupt request when the counter reaches the compare value. If the compare value lies beyond the reload value, the flag is raised on counter overflow instead.

The surrounding timer supplies the counter value, the reload value, a step pulse for each cycle in which the counter shows a new value, an overflow pulse and an update pulse. Configuration and compare values arrive through write strobes. The compare register can be written directly or through a preload buffer. That buffer is copied into the active register on each update pulse. Software can also raise the compare flag directly with a generation pulse and can clear it with a clear pulse.

Top module: `oc_channel`

## Requirements
- R1: After synchronous reset, ch_pin is 0, cmp_flag is 0, irq is 0 and chan_dir is 0. All configuration fields and both compare registers reset to 0.
- R2: With direction 0, a match event is cnt_step high with cnt_val equal to the active compare value. On a match event, mode 1 sets the reference high, mode 2 sets it low and mode 3 inverts it. Each change is visible on the next clock edge. Without a match event these modes hold the reference.
- R3: Mode 4 drives the reference low and mode 5 drives it high on every clock edge, regardless of the counter.
- R4: Mode 6 (PWM1) makes the reference high exactly when cnt_val is below the active compare value. Mode 7 (PWM2) makes it high exactly when cnt_val is not below it. Both are evaluated on every clock edge, so leaving frozen mode updates the reference at once.
- R5: Mode 0 (frozen) leaves the reference unchanged whatever the counter and compare values are.
- R6: With preload off, a compare write updates the active compare value on the same edge. With preload on, the write only fills the buffer, and the active value takes the buffer content on an edge where upd_evt is high.
- R7: A match event sets cmp_flag on the next edge when the active compare value is not greater than reload_val.
- R8: When the active compare value is greater than reload_val, ovf_evt sets cmp_flag on the next edge.
- R9: A cmp_gen pulse sets cmp_flag on the next edge, in any mode or direction.
- R10: flag_clr clears cmp_flag on the next edge. If a set condition occurs in the same cycle, the set wins.
- R11: irq is high exactly when cmp_flag is high and the interrupt-enable field is 1.
- R12: When the enable field is 1, ch_pin equals the reference XOR the polarity field (0 active high, 1 active low). When the enable field is 0, ch_pin equals the polarity field, which is its inactive level.
- R13: A configuration write changes the 2-bit direction field only if the stored enable field is 0 before the write. While the direction is nonzero (input use), the reference is held low and match and overflow events do not set the flag.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Current time-base counter value |
| reload_val | input | CW | Current counter reload value |
| cnt_step | input | 1 | Counter presents a new value this cycle |
| ovf_evt | input | 1 | Counter overflow pulse |
| upd_evt | input | 1 | Update event pulse (loads preloaded compare) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Reference mode 0..7 |
| cfg_preload | input | 1 | Compare preload enable |
| cfg_pol | input | 1 | Pin polarity, 1 = active low |
| cfg_en | input | 1 | Pin enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_dir | input | 2 | Direction, 0 = compare output |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value to write |
| flag_clr | input | 1 | Clear the compare flag |
| cmp_gen | input | 1 | Software compare event |
| ch_pin | output | 1 | Channel output pin |
| cmp_flag | output | 1 | Compare flag |
| irq | output | 1 | Interrupt request |
| chan_dir | output | 2 | Stored direction field |

## Verification
A wrong reference register shows on ch_pin one edge after the faulty update whenever the channel is enabled. The error stays visible until a force or PWM mode overwrites it. A stale active compare value surfaces later, at the first counter value where the match, PWM threshold or overflow-flag decision differs, so random counter and compare values are kept in a small range to make such points frequent. Flag and direction faults appear on cmp_flag, irq and chan_dir on the edge after the causing stimulus.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OCM_FROZEN  = 3'd0,
        OCM_SET     = 3'd1,
        OCM_CLEAR   = 3'd2,
        OCM_TOGGLE  = 3'd3,
        OCM_FORCE_L = 3'd4,
        OCM_FORCE_H = 3'd5,
        OCM_PWM_A   = 3'd6,
        OCM_PWM_B   = 3'd7
    } oc_mode_e;

    localparam int DIR_W = 2;

    typedef struct packed {
        oc_mode_e           mode;
        logic               preload;
        logic               pol;
        logic               en;
        logic               irq_en;
        logic [DIR_W-1:0]   dir;
    } oc_cfg_t;

    localparam oc_cfg_t CFG_RESET = '{mode: OCM_FROZEN, preload: 1'b0, pol: 1'b0,
                                      en: 1'b0, irq_en: 1'b0, dir: '0};

    // Next reference level for one clock edge.
    function automatic logic ref_next(input oc_mode_e mode, input logic cur,
                                      input logic match, input logic below);
        logic r;
        r = cur;
        unique case (mode)
            OCM_FROZEN:  r = cur;
            OCM_SET:     r = match ? 1'b1 : cur;
            OCM_CLEAR:   r = match ? 1'b0 : cur;
            OCM_TOGGLE:  r = match ? ~cur : cur;
            OCM_FORCE_L: r = 1'b0;
            OCM_FORCE_H: r = 1'b1;
            OCM_PWM_A:   r = below;
            OCM_PWM_B:   r = ~below;
            default:     r = cur;
        endcase
        return r;
    endfunction

    // Pin level from reference, polarity and enable.
    function automatic logic pin_level(input logic refl, input logic pol, input logic en);
        return en ? (refl ^ pol) : pol;
    endfunction

endpackage

// File: rtl/oc_regs.sv
module oc_regs
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  oc_cfg_t         cfg_wr,
    input  logic            cmp_we,
    input  logic [CW-1:0]   cmp_wdata,
    input  logic            upd_evt,
    output oc_cfg_t         cfg_q,
    output logic [CW-1:0]   cmp_act
);

    logic [CW-1:0] cmp_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q.mode    <= cfg_wr.mode;
            cfg_q.preload <= cfg_wr.preload;
            cfg_q.pol     <= cfg_wr.pol;
            cfg_q.en      <= cfg_wr.en;
            cfg_q.irq_en  <= cfg_wr.irq_en;
            if (!cfg_q.en)
                cfg_q.dir <= cfg_wr.dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf <= '0;
            cmp_act <= '0;
        end else begin
            if (cmp_we)
                cmp_buf <= cmp_wdata;
            if (cmp_we && !cfg_q.preload)
                cmp_act <= cmp_wdata;
            else if (upd_evt && cfg_q.preload)
                cmp_act <= cmp_buf;
        end
    end

    p_dir_locked_r13: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_we) |=> $stable(cfg_q.dir));

    p_preload_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.preload && !upd_evt) |=> $stable(cmp_act));

endmodule

// File: rtl/oc_flag.sv
module oc_flag #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cnt_val,
    input  logic [CW-1:0]   reload_val,
    input  logic            cnt_step,
    input  logic            ovf_evt,
    input  logic [CW-1:0]   cmp_act,
    input  logic            out_dir,
    input  logic            cmp_gen,
    input  logic            flag_clr,
    output logic            match_evt,
    output logic            flag_q
);

    logic beyond;
    logic set_flag;

    always_comb begin
        beyond    = cmp_act > reload_val;
        match_evt = out_dir && cnt_step && (cnt_val == cmp_act);
        set_flag  = cmp_gen
                  || (match_evt && !beyond)
                  || (out_dir && ovf_evt && beyond);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    p_gen_sets_r9: assert property (@(posedge clk) disable iff (rst)
        cmp_gen |=> flag_q);

    p_clr_wins_alone_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cmp_gen && !cnt_step && !ovf_evt) |=> !flag_q);

endmodule

// File: rtl/oc_refgen.sv
module oc_refgen
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  oc_mode_e        mode,
    input  logic            out_dir,
    input  logic [CW-1:0]   cnt_val,
    input  logic [CW-1:0]   cmp_act,
    input  logic            match_evt,
    output logic            ref_q
);

    logic below;
    logic ref_d;

    always_comb begin
        below = cnt_val < cmp_act;
        ref_d = out_dir ? ref_next(mode, ref_q, match_evt, below) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= 1'b0;
        else
            ref_q <= ref_d;
    end

    p_force_low_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == OCM_FORCE_L) |=> !ref_q);

    p_force_high_r3: assert property (@(posedge clk) disable iff (rst)
        (out_dir && mode == OCM_FORCE_H) |=> ref_q);

    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (out_dir && mode == OCM_FROZEN) |=> $stable(ref_q));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   cnt_val,
    input  logic [CW-1:0]   reload_val,
    input  logic            cnt_step,
    input  logic            ovf_evt,
    input  logic            upd_evt,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_mode,
    input  logic            cfg_preload,
    input  logic            cfg_pol,
    input  logic            cfg_en,
    input  logic            cfg_irq_en,
    input  logic [1:0]      cfg_dir,
    input  logic            cmp_we,
    input  logic [CW-1:0]   cmp_wdata,
    input  logic            flag_clr,
    input  logic            cmp_gen,
    output logic            ch_pin,
    output logic            cmp_flag,
    output logic            irq,
    output logic [1:0]      chan_dir
);

    oc_cfg_t        cfg_wr;
    oc_cfg_t        cfg_q;
    logic [CW-1:0]  cmp_act;
    logic           out_dir;
    logic           match_evt;
    logic           ref_q;
    logic           flag_q;

    always_comb begin
        cfg_wr.mode    = oc_mode_e'(cfg_mode);
        cfg_wr.preload = cfg_preload;
        cfg_wr.pol     = cfg_pol;
        cfg_wr.en      = cfg_en;
        cfg_wr.irq_en  = cfg_irq_en;
        cfg_wr.dir     = cfg_dir;
    end

    oc_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wr    (cfg_wr),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .upd_evt   (upd_evt),
        .cfg_q     (cfg_q),
        .cmp_act   (cmp_act)
    );

    assign out_dir = (cfg_q.dir == '0);

    oc_flag #(.CW(CW)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .cnt_val    (cnt_val),
        .reload_val (reload_val),
        .cnt_step   (cnt_step),
        .ovf_evt    (ovf_evt),
        .cmp_act    (cmp_act),
        .out_dir    (out_dir),
        .cmp_gen    (cmp_gen),
        .flag_clr   (flag_clr),
        .match_evt  (match_evt),
        .flag_q     (flag_q)
    );

    oc_refgen #(.CW(CW)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_q.mode),
        .out_dir   (out_dir),
        .cnt_val   (cnt_val),
        .cmp_act   (cmp_act),
        .match_evt (match_evt),
        .ref_q     (ref_q)
    );

    always_comb begin
        ch_pin   = pin_level(ref_q, cfg_q.pol, cfg_q.en);
        cmp_flag = flag_q;
        irq      = flag_q & cfg_q.irq_en;
        chan_dir = cfg_q.dir;
    end

    p_pin_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !cfg_q.en) |=> (ch_pin == cfg_q.pol));

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> cmp_flag);

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst;
    logic [CW-1:0] cnt_val, reload_val, cmp_wdata;
    logic cnt_step, ovf_evt, upd_evt, cfg_we, cfg_preload, cfg_pol, cfg_en, cfg_irq_en;
    logic [2:0] cfg_mode;
    logic [1:0] cfg_dir;
    logic cmp_we, flag_clr, cmp_gen;
    logic ch_pin, cmp_flag, irq;
    logic [1:0] chan_dir;

    always #5 clk = ~clk;

    oc_channel #(.CW(CW)) dut (.*);

    int n_tests = 0;
    int n_fail  = 0;

    // bench model state
    logic [2:0]    m_mode;
    logic          m_pre, m_pol, m_en, m_ie;
    logic [1:0]    m_dir;
    logic [CW-1:0] m_act, m_buf;
    logic          m_ref, m_flag;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cnt_step = 0; ovf_evt = 0; upd_evt = 0; cfg_we = 0; cmp_we = 0;
        flag_clr = 0; cmp_gen = 0;
    endtask

    function automatic logic model_ref(input logic [2:0] md, input logic cur, input logic mt, input logic bl);
        case (md)
            3'd0: return cur;
            3'd1: return mt ? 1'b1 : cur;
            3'd2: return mt ? 1'b0 : cur;
            3'd3: return mt ? ~cur : cur;
            3'd4: return 1'b0;
            3'd5: return 1'b1;
            3'd6: return bl;
            default: return ~bl;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] md, input logic en);
        if (!en) return "R12";
        case (md)
            3'd0: return "R5";
            3'd1, 3'd2, 3'd3: return "R2";
            3'd4, 3'd5: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Apply current inputs for one edge, update the model, compare after the edge.
    task automatic tick(input string tag);
        logic outd, mt, beyond, setf, nref;
        string t;
        outd   = (m_dir == 2'd0);
        mt     = outd && cnt_step && (cnt_val == m_act);
        beyond = m_act > reload_val;
        setf   = cmp_gen || (mt && !beyond) || (outd && ovf_evt && beyond);
        nref   = outd ? model_ref(m_mode, m_ref, mt, cnt_val < m_act) : 1'b0;
        t = (tag == "") ? mode_tag(m_mode, m_en) : tag;
        @(posedge clk);
        m_ref = nref;
        if (setf) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
        if (cmp_we && !m_pre) m_act = cmp_wdata;
        else if (upd_evt && m_pre) m_act = m_buf;
        if (cmp_we) m_buf = cmp_wdata;
        if (cfg_we) begin
            if (!m_en) m_dir = cfg_dir;
            m_mode = cfg_mode; m_pre = cfg_preload; m_pol = cfg_pol;
            m_en = cfg_en; m_ie = cfg_irq_en;
        end
        @(negedge clk);
        chk(t, "ch_pin", ch_pin, m_en ? (m_ref ^ m_pol) : m_pol);
        chk((tag == "") ? "R7" : tag, "cmp_flag", cmp_flag, m_flag);
        chk((tag == "") ? "R11" : tag, "irq", irq, m_flag & m_ie);
        chk((tag == "") ? "R13" : tag, "chan_dir", chan_dir, m_dir);
        idle_inputs();
    endtask

    task automatic wcfg(input logic [2:0] md, input logic pre, input logic pol,
                        input logic en, input logic ie, input logic [1:0] dr, input string tag);
        cfg_we = 1; cfg_mode = md; cfg_preload = pre; cfg_pol = pol;
        cfg_en = en; cfg_irq_en = ie; cfg_dir = dr;
        tick(tag);
    endtask

    task automatic wcmp(input logic [CW-1:0] v, input string tag);
        cmp_we = 1; cmp_wdata = v;
        tick(tag);
    endtask

    task automatic stepc(input logic [CW-1:0] c, input string tag);
        cnt_val = c; cnt_step = 1;
        tick(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        cnt_val = 0; reload_val = 16'd9; cmp_wdata = 0;
        cfg_mode = 0; cfg_preload = 0; cfg_pol = 0; cfg_en = 0; cfg_irq_en = 0; cfg_dir = 0;
        m_mode = 0; m_pre = 0; m_pol = 0; m_en = 0; m_ie = 0; m_dir = 0;
        m_act = 0; m_buf = 0; m_ref = 0; m_flag = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "ch_pin", ch_pin, 0);
        chk("R1", "cmp_flag", cmp_flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "chan_dir", chan_dir, 0);

        // R2 toggle on match, active high, enabled, irq on
        wcmp(16'd4, "R6");
        wcfg(3'd3, 0, 0, 1, 1, 2'd0, "R12");
        stepc(16'd3, "R2");
        stepc(16'd4, "R2");
        chk("R2", "toggle high", ch_pin, 1);
        chk("R7", "flag on match", cmp_flag, 1);
        chk("R11", "irq", irq, 1);
        cnt_val = 16'd4; tick("R2");                 // no step: hold
        chk("R2", "hold without step", ch_pin, 1);
        // R10 clear, then clear with simultaneous match
        flag_clr = 1; tick("R10");
        chk("R10", "cleared", cmp_flag, 0);
        flag_clr = 1; cnt_val = 16'd4; cnt_step = 1; tick("R10");
        chk("R10", "set wins", cmp_flag, 1);
        // R12 polarity low
        wcfg(3'd5, 0, 1, 1, 1, 2'd0, "R12");
        tick("R3");
        chk("R3", "force high inverted", ch_pin, 0);
        // R6 preload: write buffers, only update loads
        wcfg(3'd6, 1, 0, 1, 0, 2'd0, "R6");
        wcmp(16'd2, "R6");
        cnt_val = 16'd3; tick("R6");
        chk("R6", "old compare kept", ch_pin, 1);    // 3 < 4
        upd_evt = 1; cnt_val = 16'd3; tick("R6");
        cnt_val = 16'd3; tick("R4");
        chk("R4", "PWM after reload", ch_pin, 0);    // 3 < 2 false
        // R8 overflow flag when compare > reload
        flag_clr = 1; tick("R10");
        wcfg(3'd0, 0, 0, 1, 1, 2'd0, "R5");
        wcmp(16'd12, "R8");
        ovf_evt = 1; cnt_val = 0; cnt_step = 1; tick("R8");
        chk("R8", "overflow flag", cmp_flag, 1);
        // R9 generation and R13 direction lock
        flag_clr = 1; tick("R10");
        wcfg(3'd0, 0, 0, 1, 0, 2'd2, "R13");
        chk("R13", "dir locked", chan_dir, 0);
        wcfg(3'd0, 0, 0, 0, 0, 2'd1, "R13");
        wcfg(3'd0, 0, 0, 0, 0, 2'd1, "R13");
        chk("R13", "dir written", chan_dir, 1);
        cmp_gen = 1; tick("R9");
        chk("R9", "gen sets flag", cmp_flag, 1);
        wcfg(3'd0, 0, 0, 0, 0, 2'd0, "R13");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cnt_val    = 16'($urandom_range(0, 15));
            reload_val = 16'($urandom_range(4, 15));
            cnt_step   = ($urandom_range(0, 3) != 0);
            ovf_evt    = ($urandom_range(0, 7) == 0);
            upd_evt    = ($urandom_range(0, 7) == 0);
            flag_clr   = ($urandom_range(0, 5) == 0);
            cmp_gen    = ($urandom_range(0, 31) == 0);
            cmp_we     = ($urandom_range(0, 9) == 0);
            cmp_wdata  = 16'($urandom_range(0, 17));
            cfg_we     = ($urandom_range(0, 19) == 0);
            cfg_mode   = 3'($urandom_range(0, 7));
            cfg_preload = 1'($urandom_range(0, 1));
            cfg_pol    = 1'($urandom_range(0, 1));
            cfg_en     = ($urandom_range(0, 3) != 0);
            cfg_irq_en = 1'($urandom_range(0, 1));
            cfg_dir    = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            tick("");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule